// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept, based only on its 48-bit destination address. The address is first compared in parallel against a bank of exact-match entries. Each entry can be switched on or off with its own valid flag. If no valid entry matches, a 12-bit hash taken from the last two address bytes indexes a 4096-bit multicast table, and a set bit there also accepts the frame.

Software programs the entries, the table words and the hash-offset select through a single-cycle write port. The frame parser presents the destination address with a one-cycle strobe. One clock later the block answers with an accept/reject flag and a one-cycle valid pulse. Every frame accepted through the hash table bumps a saturating counter.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, accept_valid_o and accept_o are 0 and mc_count_o is 0. All entries are invalid and every table bit is clear, so any lookup is rejected.
- R2: The write address map works as follows. Addresses 0x00..0x1F hold the entries: address bit 0 selects the low (0) or high (1) word, and bits 4:1 select the entry. 0x40 holds the hash-offset select in wdata[1:0]. 0x80..0xFF hold the table words, with address bits 6:0 as the word index.
- R3: The address is taken as da_i[8k+7:8k] = byte k. The low word of an entry holds bytes 0..3, with byte 0 in bits 7:0. The high word holds bytes 4..5 in bits 15:0 and the entry valid flag in bit 31. Bits 30:16 have no effect on matching. A full 48-bit match against a valid entry accepts the frame.
- R4: An entry whose valid flag is 0 never matches.
- R5: An exact match accepts the frame without consulting the table, and mc_count_o does not change.
- R6: The hash source is {byte5, byte4}. It is shifted right by 4, 3, 2 or 0 for select values 0, 1, 2 or 3, and the low 12 bits are kept. Hash bits 11:5 pick the table word and bits 4:0 pick the bit. A set bit accepts the frame when no exact match exists.
- R7: Each acceptance through the table raises mc_count_o by exactly one. Nothing else changes it.
- R8: mc_count_o saturates at all ones instead of wrapping.
- R9: accept_valid_o is high exactly one clock after each cycle with da_valid_i high, including back-to-back strobes. accept_o is 0 whenever accept_valid_o is 0.
- R10: A lookup in the same cycle as a configuration write is judged against the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 8 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| da_valid_i | input | 1 | Destination address valid strobe |
| da_i | input | 48 | Destination address, byte k at bits 8k+7:8k |
| accept_valid_o | output | 1 | Decision valid pulse |
| accept_o | output | 1 | Frame accepted |
| mc_count_o | output | CNT_W | Saturating count of table-based accepts |

## Verification
Two events can fall in the same cycle: a configuration write and a lookup that depends on the very entry or table word being written. The bench raises the write enable and the address strobe on the same edge. In one case it clears an entry's valid flag while that entry's address is presented. In the other it clears a table word while an address hashing into that word is presented. Both decisions must reflect the old contents, and the counter must move with the old table bit. A follow-up lookup must then show the new contents.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

  localparam int unsigned ADDR_W = 48;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    HSEL_SH4 = 2'd0,
    HSEL_SH3 = 2'd1,
    HSEL_SH2 = 2'd2,
    HSEL_SH0 = 2'd3
  } hash_sel_e;

  function automatic logic [15:0] hash_shift(logic [15:0] src, hash_sel_e sel);
    unique case (sel)
      HSEL_SH4: hash_shift = src >> 4;
      HSEL_SH3: hash_shift = src >> 3;
      HSEL_SH2: hash_shift = src >> 2;
      default:  hash_shift = src;
    endcase
  endfunction

endpackage

// File: rtl/rx_da_cam.sv
module rx_da_cam
  import rx_da_filter_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned EIDX_W = $clog2(N_ENTRIES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [EIDX_W-1:0]   wr_idx_i,
  input  logic                wr_hi_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   da_i,
  output logic                hit_o
);

  logic [N_ENTRIES-1:0] match;
  logic [N_ENTRIES-1:0] vld;
  logic                 unused_bits;

  assign unused_bits = ^wr_data_i[30:16];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        vld_q;
    logic        sel;

    assign sel = wr_en_i && (wr_idx_i == EIDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q  <= '0;
        hi_q  <= '0;
        vld_q <= 1'b0;
      end else if (sel) begin
        if (wr_hi_i) begin
          hi_q  <= wr_data_i[15:0];
          vld_q <= wr_data_i[31];
        end else begin
          lo_q <= wr_data_i;
        end
      end
    end

    assign vld[g]   = vld_q;
    assign match[g] = vld_q && ({hi_q, lo_q} == da_i);
  end

  assign hit_o = |match;

  // R4: an entry whose valid flag is clear cannot be the source of a hit
  a_r4_no_hit_all_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld == '0) |-> !hit_o);

endmodule

// File: rtl/rx_da_hash.sv
module rx_da_hash
  import rx_da_filter_pkg::*;
#(
  parameter int unsigned HASH_WORDS = 128,
  localparam int unsigned HIDX_W = $clog2(HASH_WORDS),
  localparam int unsigned HASH_W = HIDX_W + 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [HIDX_W-1:0]   wr_idx_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic                sel_wr_i,
  input  logic [1:0]          sel_i,
  input  logic [15:0]         src_i,
  output logic                hit_o
);

  logic [WORD_W-1:0] tbl_q [HASH_WORDS];
  hash_sel_e         sel_q;
  logic [15:0]       shifted;
  logic [HASH_W-1:0] idx;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= HSEL_SH4;
    else if (sel_wr_i) sel_q <= hash_sel_e'(sel_i);
  end

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     tbl_q[w] <= '0;
      else if (wr_en_i && wr_idx_i == HIDX_W'(w))      tbl_q[w] <= wr_data_i;
    end
  end

  assign shifted = hash_shift(src_i, sel_q);
  assign idx     = shifted[HASH_W-1:0];
  assign word    = tbl_q[idx[HASH_W-1:5]];
  assign hit_o   = word[idx[4:0]];

endmodule

// File: rtl/rx_da_sat_cnt.sv
module rx_da_sat_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
#(
  parameter int unsigned N_ENTRIES  = 16,
  parameter int unsigned HASH_WORDS = 128,
  parameter int unsigned CNT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              da_valid_i,
  input  logic [47:0]       da_i,
  output logic              accept_valid_o,
  output logic              accept_o,
  output logic [CNT_W-1:0]  mc_count_o
);

  localparam int unsigned EIDX_W  = $clog2(N_ENTRIES);
  localparam int unsigned HIDX_W  = $clog2(HASH_WORDS);
  localparam logic [5:0]  ENT_LIM = 6'(N_ENTRIES);

  logic cam_we, hash_we, sel_we;
  logic cam_hit, hash_hit, mc_inc;
  logic acc_vld_q, acc_q;

  // map: 00xx_xxxx entries, 01xx_xxxx offset select, 1xxx_xxxx table words
  assign cam_we  = cfg_we_i && (cfg_addr_i[7:6] == 2'b00) && ({1'b0, cfg_addr_i[5:1]} < ENT_LIM);
  assign sel_we  = cfg_we_i && (cfg_addr_i[7:6] == 2'b01);
  assign hash_we = cfg_we_i && cfg_addr_i[7];

  rx_da_cam #(.N_ENTRIES(N_ENTRIES)) u_cam (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cam_we),
    .wr_idx_i  (cfg_addr_i[EIDX_W:1]),
    .wr_hi_i   (cfg_addr_i[0]),
    .wr_data_i (cfg_wdata_i),
    .da_i      (da_i),
    .hit_o     (cam_hit)
  );

  rx_da_hash #(.HASH_WORDS(HASH_WORDS)) u_hash (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (hash_we),
    .wr_idx_i  (cfg_addr_i[HIDX_W-1:0]),
    .wr_data_i (cfg_wdata_i),
    .sel_wr_i  (sel_we),
    .sel_i     (cfg_wdata_i[1:0]),
    .src_i     (da_i[47:32]),
    .hit_o     (hash_hit)
  );

  // table is a fallback only
  assign mc_inc = da_valid_i && !cam_hit && hash_hit;

  rx_da_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (mc_inc),
    .cnt_o  (mc_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_vld_q <= 1'b0;
      acc_q     <= 1'b0;
    end else begin
      acc_vld_q <= da_valid_i;
      acc_q     <= da_valid_i && (cam_hit || hash_hit);
    end
  end

  assign accept_valid_o = acc_vld_q;
  assign accept_o       = acc_q;

  a_r9_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    da_valid_i |=> accept_valid_o);

  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !da_valid_i |=> !accept_valid_o);

  a_r9_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_valid_o |-> !accept_o);

  a_r5_exact_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_valid_i && cam_hit) |=> (accept_o && $stable(mc_count_o)));

endmodule

// File: tb/rx_da_filter_tb.sv
`timescale 1ns/1ps
module rx_da_filter_tb;

  localparam int unsigned CW = 4;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic          dv = 1'b0;
  logic [47:0]   da = '0;
  logic          acc_vld, acc;
  logic [CW-1:0] cnt;

  int total = 0;
  int bad = 0;
  logic [CW-1:0] mc_exp = '0;

  always #4 clk = ~clk;

  rx_da_filter #(.N_ENTRIES(16), .HASH_WORDS(128), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .da_valid_i(dv), .da_i(da), .accept_valid_o(acc_vld), .accept_o(acc), .mc_count_o(cnt)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic look(logic [47:0] a, output logic v, output logic r, output logic [CW-1:0] c);
    @(negedge clk); dv = 1'b1; da = a;
    @(negedge clk); dv = 1'b0;
    v = acc_vld; r = acc; c = cnt;
  endtask

  function automatic logic [47:0] ent(int i);
    logic [15:0] h;
    logic [31:0] l;
    h = 16'h0a00 + 16'(i) * 16'h0111;
    l = 32'h1234_5678 ^ (32'(i) * 32'h0101_0101);
    return {h, l};
  endfunction

  function automatic logic [31:0] pat(int w);
    return (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [11:0] hidx(logic [47:0] a, int sel);
    logic [15:0] s;
    int sh;
    sh = (sel == 0) ? 4 : (sel == 1) ? 3 : (sel == 2) ? 2 : 0;
    s = a[47:32] >> sh;
    return s[11:0];
  endfunction

  function automatic logic exp_hash(logic [47:0] a, int sel);
    logic [11:0] ix;
    logic [31:0] w;
    ix = hidx(a, sel);
    w = pat(int'(ix[11:5]));
    return w[ix[4:0]];
  endfunction

  function automatic logic [CW-1:0] sat_inc(logic [CW-1:0] c);
    return (c == CMAX) ? c : c + 1'b1;
  endfunction

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic v, r;
    logic [CW-1:0] c;
    logic [47:0] x;
    logic [11:0] ix;

    repeat (3) @(negedge clk);
    chk("R1 reset accept_valid", int'(acc_vld), 0);
    chk("R1 reset count", int'(cnt), 0);
    rst_n = 1'b1;
    look(ent(3), v, r, c);
    chk("R1 empty reject", int'(r), 0);
    chk("R9 valid pulse", int'(v), 1);
    @(negedge clk);
    chk("R9 pulse single", int'(acc_vld), 0);
    look(48'hFFFF_FFFF_FFFF, v, r, c);
    chk("R1 empty reject ones", int'(r), 0);

    // R2 R3: program every entry, junk in ignored high bits
    for (int i = 0; i < 16; i++) begin
      x = ent(i);
      wr(8'(2 * i), x[31:0]);
      wr(8'(2 * i + 1), {1'b1, 15'(16'h5AA5 + 16'(i)), x[47:32]});
    end
    for (int i = 0; i < 16; i++) begin
      look(ent(i), v, r, c);
      chk("R3 exact hit", int'(r), 1);
      chk("R5 exact no count", int'(c), 0);
      x = ent(i) ^ 48'h01;
      look(x, v, r, c);
      chk("R3 byte0 miss", int'(r), 0);
      x = ent(i) ^ 48'h8000_0000_0000;
      look(x, v, r, c);
      chk("R3 byte5 miss", int'(r), 0);
    end

    // R4: drop odd entries
    for (int i = 1; i < 16; i += 2) begin
      x = ent(i);
      wr(8'(2 * i + 1), {1'b0, 15'h7FFF, x[47:32]});
    end
    for (int i = 0; i < 16; i++) begin
      look(ent(i), v, r, c);
      chk("R4 invalid skipped", int'(r), (i % 2 == 0) ? 1 : 0);
    end

    // R5 R6 R7: table bit for ent(0) with select 0
    wr(8'h40, 32'hFFFF_FFFC);
    ix = hidx(ent(0), 0);
    wr(8'h80 | 8'(ix[11:5]), 32'h1 << ix[4:0]);
    look(ent(0), v, r, c);
    chk("R5 exact over hash", int'(r), 1);
    chk("R5 count unchanged", int'(c), 0);
    x = ent(0) ^ 48'h0000_0000_00F0;
    look(x, v, r, c);
    mc_exp = sat_inc(mc_exp);
    chk("R6 hash accept", int'(r), 1);
    chk("R7 count step", int'(c), int'(mc_exp));

    // R10: same-cycle write and lookup
    @(negedge clk);
    we = 1'b1; addr = 8'h80 | 8'(ix[11:5]); wdata = 32'h0;
    dv = 1'b1; da = x;
    @(negedge clk);
    we = 1'b0; dv = 1'b0;
    mc_exp = sat_inc(mc_exp);
    chk("R10 old table bit", int'(acc), 1);
    chk("R10 count with old bit", int'(cnt), int'(mc_exp));
    look(x, v, r, c);
    chk("R10 new table bit", int'(r), 0);
    chk("R7 no count on reject", int'(c), int'(mc_exp));

    @(negedge clk);
    x = ent(2);
    we = 1'b1; addr = 8'h05; wdata = {1'b0, 15'h0, x[47:32]};
    dv = 1'b1; da = x;
    @(negedge clk);
    we = 1'b0; dv = 1'b1; da = x;
    chk("R10 old entry", int'(acc), 1);
    @(negedge clk);
    dv = 1'b0;
    chk("R9 back to back", int'(acc_vld), 1);
    chk("R10 new entry", int'(acc), 0);

    // R6 sweep: all entries off, table patterned
    for (int i = 0; i < 16; i++) wr(8'(2 * i + 1), 32'h0);
    for (int w = 0; w < 128; w++) wr(8'h80 | 8'(w), pat(w));
    for (int sel = 0; sel < 4; sel++) begin
      wr(8'h40, 32'(sel));
      for (int s = sel; s < 65536; s += 41) begin
        x = {16'(s), 32'hC0FF_EE00 ^ 32'(s)};
        look(x, v, r, c);
        if (exp_hash(x, sel)) mc_exp = sat_inc(mc_exp);
        chk("R6 hash index", int'(r), int'(exp_hash(x, sel)));
        chk("R8 count", int'(c), int'(mc_exp));
      end
    end
    chk("R8 saturated", int'(cnt), int'(CMAX));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule